// File: doc/BRIEF.md
# Serial Flash Identification and Power-Down Responder

This block is the device side of a serial flash interface for the identification and power-mode commands only. It watches chip select, the serial clock and two data lines. It decodes an 8-bit opcode and answers the identification commands by shifting bytes out, most significant bit first. The answers are the three-byte vendor/type/capacity query, the manufacturer/device pair (on one line or on two lines), the repeating device ID and the 64-bit unique number. All identification values are parameters. Array access and the status register are not part of this block.

The block also holds a power-down state. While it is in that state, only the release opcode is acted on. After the release frame ends there is a fixed recovery interval, set by a parameter, during which every opcode is still ignored.

The block runs on a fast system clock. The serial clock and chip select are sampled as ordinary inputs, and their edges are detected. Input bits are taken at rising serial clock edges, and output bits change one system clock after falling edges. Serial clock mode 0 is assumed (idle low).

Top module: `flashid_responder`

## Requirements
- R1: After reset, `io_oe` is 2'b00 and `pwr_down` is 0.
- R2: Opcode 9Fh returns MFR_ID, MEM_TYPE, MEM_CAP on `io_out[1]`, and the three-byte sequence wraps for as long as clocks continue. The first bit appears after the falling edge that follows the eighth opcode rising edge.
- R3: Opcode 90h is followed by 24 address bits on `io_in[0]`. If the last address byte equals 01h, the answer is DEV_ID then MFR_ID. Any other value gives MFR_ID then DEV_ID. The pair repeats while `cs_n` stays low.
- R4: Opcode 92h takes its 24 address bits in 12 clocks on two lines, `io_in[1]` carrying the higher bit of each pair. It answers with the same byte order rule as R3, on two lines: `io_out[1]` carries bits 7,5,3,1 and `io_out[0]` carries bits 6,4,2,0, so one byte takes four clocks.
- R5: Opcode ABh is followed by 24 dummy clocks. It then repeats DEV_ID, whether or not the block is powered down.
- R6: Opcode 4Bh is followed by 32 dummy clocks. It then returns UNIQUE_ID byte by byte from bits 63:56 down to bits 7:0, and wraps after the eighth byte.
- R7: Bits are sampled at rising serial clock edges and changed at falling edges. `io_oe` is 2'b10 in a single-line answer and 2'b11 in a dual-line answer. It is 2'b00 during the opcode and address phases and from the first clock on which `cs_n` is high.
- R8: A frame holding opcode B9h sets `pwr_down` to 1 when `cs_n` rises.
- R9: While `pwr_down` is 1, any opcode other than ABh is ignored: no answer is driven, and a B9h does not change the state.
- R10: An ABh frame in power-down starts a recovery interval when `cs_n` rises. `pwr_down` drops RELEASE_CYC clocks later, and any opcode during the interval is ignored.
- R11: An opcode that is not listed above is ignored until `cs_n` rises.
- R12: If `cs_n` rises before the eighth opcode bit, the frame is aborted, and a partial B9h has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| io_in | input | 2 | Data lines from the host; bit 0 is the single-line input |
| io_out | output | 2 | Data lines to the host; bit 1 is the single-line output |
| io_oe | output | 2 | Per-line output enables |
| pwr_down | output | 1 | High in power-down and during recovery |

## Verification
The bench targets several corner cases:
- The byte-order switch for the manufacturer/device pair, on one line and on two lines. A design that decodes the wrong address bit, or that shifts the dual address the wrong way, sends the pair in the wrong order.
- The wrap points after the third identification byte and after the eighth unique-ID byte. An off-by-one in the sequence length shows up there as a wrong byte.
- The first output bit, which must already be present after the falling edge that ends the input phase. A design that waits one more clock loses the top bit.
- Commands issued during power-down and during the recovery interval. An aborted B9h frame must not power the block down.
- The exact cycle at which `pwr_down` drops. A miscounted release delay fails there.

// File: rtl/flashid_pkg.sv
package flashid_pkg;

  typedef enum logic [2:0] {
    K_NONE, K_JEDEC, K_MID, K_MID2, K_RES, K_UID, K_PD
  } kind_t;

  function automatic kind_t decode_op(input logic [7:0] op);
    case (op)
      8'h9F:   return K_JEDEC;
      8'h90:   return K_MID;
      8'h92:   return K_MID2;
      8'hAB:   return K_RES;
      8'h4B:   return K_UID;
      8'hB9:   return K_PD;
      default: return K_NONE;
    endcase
  endfunction

  // rising edges between the opcode and the first output bit
  function automatic logic [5:0] pre_edges(input kind_t k);
    case (k)
      K_MID:   return 6'd24;
      K_MID2:  return 6'd12;
      K_RES:   return 6'd24;
      K_UID:   return 6'd32;
      default: return 6'd0;
    endcase
  endfunction

  // index of the last byte before the answer wraps
  function automatic logic [2:0] seq_last(input kind_t k);
    case (k)
      K_JEDEC: return 3'd2;
      K_MID:   return 3'd1;
      K_MID2:  return 3'd1;
      K_UID:   return 3'd7;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/fid_edges.sv
module fid_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  output logic rise,
  output logic fall,
  output logic cs_end
);
  logic sck_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  assign rise   = !cs_n && sck && !sck_q;
  assign fall   = !cs_n && !sck && sck_q;
  assign cs_end = cs_n && !cs_q;
endmodule

// File: rtl/fid_frontend.sv
module fid_frontend
  import flashid_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rise,
  input  logic [1:0] io_in,
  input  logic       pd,
  input  logic       releasing,
  output kind_t      kind,
  output logic       in_resp,
  output logic       swap,
  output logic       pd_req,
  output logic       rel_req
);
  typedef enum logic [1:0] {ST_OPC, ST_ADDR, ST_RESP, ST_SKIP} st_t;

  st_t        st;
  logic [5:0] cnt;
  logic [7:0] sh;

  logic [7:0] op_next;
  kind_t      op_kind;
  logic       blocked;
  logic [7:0] addr_next;
  logic       op_last;
  logic       addr_last;

  assign op_next   = {sh[6:0], io_in[0]};
  assign op_kind   = decode_op(op_next);
  assign blocked   = releasing || (pd && op_kind != K_RES);
  assign addr_next = (kind == K_MID2) ? {sh[5:0], io_in[1], io_in[0]} : {sh[6:0], io_in[0]};
  assign op_last   = (st == ST_OPC) && rise && (cnt == 6'd7);
  assign addr_last = (st == ST_ADDR) && rise && (cnt == pre_edges(kind) - 6'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_OPC;
      cnt     <= '0;
      sh      <= '0;
      kind    <= K_NONE;
      swap    <= 1'b0;
      pd_req  <= 1'b0;
      rel_req <= 1'b0;
    end else if (cs_n) begin
      st      <= ST_OPC;
      cnt     <= '0;
      kind    <= K_NONE;
      swap    <= 1'b0;
      pd_req  <= 1'b0;
      rel_req <= 1'b0;
    end else if (rise) begin
      case (st)
        ST_OPC: begin
          sh <= op_next;
          if (op_last) begin
            cnt <= '0;
            if (blocked) begin
              st <= ST_SKIP;
            end else if (op_kind == K_PD) begin
              pd_req <= 1'b1;
              st     <= ST_SKIP;
            end else if (op_kind == K_NONE) begin
              st <= ST_SKIP;
            end else begin
              kind    <= op_kind;
              rel_req <= (op_kind == K_RES) && pd;
              st      <= (pre_edges(op_kind) == 6'd0) ? ST_RESP : ST_ADDR;
            end
          end else begin
            cnt <= cnt + 6'd1;
          end
        end
        ST_ADDR: begin
          sh <= addr_next;
          if (addr_last) begin
            st   <= ST_RESP;
            swap <= (addr_next == 8'h01);
          end else begin
            cnt <= cnt + 6'd1;
          end
        end
        default: ;
      endcase
    end
  end

  assign in_resp = (st == ST_RESP);

  assert_pd_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_last && !cs_n && pd && op_kind != K_RES) |=> (st == ST_SKIP));

  assert_unknown_skip_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_last && !cs_n && op_kind == K_NONE) |=> !in_resp);

  assert_addr_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ADDR) |-> (cnt < pre_edges(kind)));
endmodule

// File: rtl/fid_tx.sv
module fid_tx
  import flashid_pkg::*;
#(
  parameter logic [7:0]  MFR_ID    = 8'hEF,
  parameter logic [7:0]  MEM_TYPE  = 8'h30,
  parameter logic [7:0]  MEM_CAP   = 8'h12,
  parameter logic [7:0]  DEV_ID    = 8'h11,
  parameter logic [63:0] UNIQUE_ID = 64'hD1A5_0C37_9E42_B6F8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       fall,
  input  logic       in_resp,
  input  kind_t      kind,
  input  logic       swap,
  output logic [1:0] io_out,
  output logic [1:0] io_oe
);
  function automatic logic [7:0] pick(input kind_t k, input logic [2:0] i, input logic sw);
    logic [7:0] b;
    case (k)
      K_JEDEC: b = (i == 3'd0) ? MFR_ID : (i == 3'd1) ? MEM_TYPE : MEM_CAP;
      K_MID, K_MID2: b = (i[0] ^ sw) ? DEV_ID : MFR_ID;
      K_RES:   b = DEV_ID;
      K_UID:   b = UNIQUE_ID[8 * (7 - int'(i)) +: 8];
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  logic [2:0] idx, pos;
  logic [7:0] cur;
  logic       dual;
  logic       byte_done;

  assign cur       = pick(kind, idx, swap);
  assign dual      = (kind == K_MID2);
  assign byte_done = dual ? (pos == 3'd6) : (pos == 3'd7);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      pos    <= '0;
      io_out <= '0;
      io_oe  <= '0;
    end else if (cs_n || !in_resp) begin
      idx    <= '0;
      pos    <= '0;
      io_out <= '0;
      io_oe  <= '0;
    end else if (fall) begin
      if (dual) begin
        io_oe  <= 2'b11;
        io_out <= {cur[3'd7 - pos], cur[3'd6 - pos]};
      end else begin
        io_oe  <= 2'b10;
        io_out <= {cur[3'd7 - pos], 1'b0};
      end
      if (byte_done) begin
        pos <= '0;
        idx <= (idx == seq_last(kind)) ? 3'd0 : idx + 3'd1;
      end else begin
        pos <= pos + (dual ? 3'd2 : 3'd1);
      end
    end
  end

  assert_oe_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> (io_oe == 2'b00));

  assert_dual_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 2'b11) |-> (kind == K_MID2));

  assert_dual_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dual |-> !pos[0]);

  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_resp |-> (idx <= seq_last(kind)));
endmodule

// File: rtl/fid_pwr.sv
module fid_pwr #(
  parameter int RELEASE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_end,
  input  logic pd_req,
  input  logic rel_req,
  output logic pd,
  output logic releasing
);
  localparam int CW = $clog2(RELEASE_CYC + 1);
  logic [CW-1:0] cnt;
  logic          enter_ev, release_ev;

  assign enter_ev   = cs_end && pd_req && !pd;
  assign release_ev = cs_end && rel_req && pd && !releasing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd        <= 1'b0;
      releasing <= 1'b0;
      cnt       <= '0;
    end else if (enter_ev) begin
      pd <= 1'b1;
    end else if (release_ev) begin
      releasing <= 1'b1;
      cnt       <= CW'(RELEASE_CYC);
    end else if (releasing) begin
      if (cnt <= CW'(1)) begin
        pd        <= 1'b0;
        releasing <= 1'b0;
        cnt       <= '0;
      end else begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  assert_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
    enter_ev |=> pd);

  assert_release_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev |=> (releasing && pd));

  assert_release_in_pd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    releasing |-> pd);

  assert_wake_path_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd) |-> $past(releasing));
endmodule

// File: rtl/flashid_responder.sv
module flashid_responder
  import flashid_pkg::*;
#(
  parameter logic [7:0]  MFR_ID      = 8'hEF,
  parameter logic [7:0]  MEM_TYPE    = 8'h30,
  parameter logic [7:0]  MEM_CAP     = 8'h12,
  parameter logic [7:0]  DEV_ID      = 8'h11,
  parameter logic [63:0] UNIQUE_ID   = 64'hD1A5_0C37_9E42_B6F8,
  parameter int          RELEASE_CYC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic [1:0] io_in,
  output logic [1:0] io_out,
  output logic [1:0] io_oe,
  output logic       pwr_down
);
  logic  rise, fall, cs_end;
  logic  pd, releasing;
  kind_t kind;
  logic  in_resp, swap, pd_req, rel_req;

  fid_edges u_edges (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
    .rise(rise), .fall(fall), .cs_end(cs_end)
  );

  fid_frontend u_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rise(rise), .io_in(io_in),
    .pd(pd), .releasing(releasing), .kind(kind), .in_resp(in_resp),
    .swap(swap), .pd_req(pd_req), .rel_req(rel_req)
  );

  fid_tx #(
    .MFR_ID(MFR_ID), .MEM_TYPE(MEM_TYPE), .MEM_CAP(MEM_CAP),
    .DEV_ID(DEV_ID), .UNIQUE_ID(UNIQUE_ID)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fall(fall), .in_resp(in_resp),
    .kind(kind), .swap(swap), .io_out(io_out), .io_oe(io_oe)
  );

  fid_pwr #(.RELEASE_CYC(RELEASE_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .cs_end(cs_end), .pd_req(pd_req),
    .rel_req(rel_req), .pd(pd), .releasing(releasing)
  );

  assign pwr_down = pd;
endmodule

// File: tb/sim_flashid_responder.sv
`timescale 1ns/1ps
module sim_flashid_responder;
  localparam logic [7:0]  P_MFR  = 8'hEF;
  localparam logic [7:0]  P_TYPE = 8'h30;
  localparam logic [7:0]  P_CAP  = 8'h12;
  localparam logic [7:0]  P_DEV  = 8'h11;
  localparam logic [63:0] P_UID  = 64'hD1A5_0C37_9E42_B6F8;
  localparam int          P_REL  = 200;

  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1;
  logic [1:0] io_in = 2'b00;
  logic [1:0] io_out, io_oe;
  logic pwr_down;

  int n_checks = 0, n_err = 0;
  logic [1:0] last_dout, last_oe;
  bit done = 0;

  always #2.5 clk = ~clk;

  flashid_responder #(
    .MFR_ID(P_MFR), .MEM_TYPE(P_TYPE), .MEM_CAP(P_CAP), .DEV_ID(P_DEV),
    .UNIQUE_ID(P_UID), .RELEASE_CYC(P_REL)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .pwr_down(pwr_down)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pair(input logic [1:0] din);
    io_in = din; tick(2);
    sck = 1'b1; tick(4);
    sck = 1'b0; tick(4);
    last_dout = io_out; last_oe = io_oe;
  endtask

  task automatic send_single(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) pair({1'b0, b[i]});
  endtask

  task automatic send_dual(input logic [7:0] b);
    for (int i = 3; i >= 0; i--) pair({b[2*i+1], b[2*i]});
  endtask

  task automatic recv(input bit dual, output logic [7:0] b, output logic [1:0] oe);
    oe = last_oe;
    if (dual) begin
      for (int i = 3; i >= 0; i--) begin b[2*i+1] = last_dout[1]; b[2*i] = last_dout[0]; pair(2'b00); end
    end else begin
      for (int i = 7; i >= 0; i--) begin b[i] = last_dout[1]; pair(2'b00); end
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [7:0] op, input int i, input bit sw);
    case (op)
      8'h9F: return (i % 3 == 0) ? P_MFR : (i % 3 == 1) ? P_TYPE : P_CAP;
      8'h90, 8'h92: return (((i % 2) == 1) != sw) ? P_DEV : P_MFR;
      8'hAB: return P_DEV;
      8'h4B: return 8'(P_UID >> (8 * (7 - (i % 8))));
      default: return 8'h00;
    endcase
  endfunction

  // full frame: opcode, its address or dummy phase, nbytes of answer
  task automatic frame(input logic [7:0] op, input logic [7:0] alo, input int nbytes,
                       input bit expect_resp, input string req);
    logic [7:0] b; logic [1:0] oe;
    bit dual = (op == 8'h92);
    cs_n = 1'b0; tick(2);
    send_single(op);
    case (op)
      8'h90: begin send_single(8'($urandom)); send_single(8'($urandom)); send_single(alo); end
      8'h92: begin send_dual(8'($urandom)); send_dual(8'($urandom)); send_dual(alo); end
      8'hAB: for (int k = 0; k < 3; k++) send_single(8'($urandom));
      8'h4B: for (int k = 0; k < 4; k++) send_single(8'($urandom));
      default: ;
    endcase
    for (int i = 0; i < nbytes; i++) begin
      recv(dual, b, oe);
      if (expect_resp) begin
        chk(b == exp_byte(op, i, alo == 8'h01), req, b, exp_byte(op, i, alo == 8'h01));
        chk(oe == (dual ? 2'b11 : 2'b10), "R7", oe, dual ? 2'b11 : 2'b10);
      end else begin
        chk(oe == 2'b00, req, oe, 2'b00);
      end
    end
    cs_n = 1'b1; tick(4);
    chk(io_oe == 2'b00, "R7", io_oe, 2'b00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [5];
    ops = '{8'h9F, 8'h90, 8'h92, 8'hAB, 8'h4B};
    void'($urandom(32'h5eed_0042));
    last_dout = 2'b00; last_oe = 2'b00;
    tick(5);
    chk(io_oe == 2'b00, "R1", io_oe, 2'b00);
    chk(pwr_down == 1'b0, "R1", pwr_down, 1'b0);
    rst_n = 1'b1; tick(3);

    frame(8'h9F, 8'h00, 7, 1, "R2");
    frame(8'h90, 8'h00, 4, 1, "R3");
    frame(8'h90, 8'h01, 4, 1, "R3");
    frame(8'h90, 8'h03, 2, 1, "R3");
    frame(8'h92, 8'h00, 4, 1, "R4");
    frame(8'h92, 8'h01, 4, 1, "R4");
    frame(8'hAB, 8'h00, 3, 1, "R5");
    frame(8'h4B, 8'h00, 10, 1, "R6");
    frame(8'h5A, 8'h00, 2, 0, "R11");
    frame(8'h00, 8'h00, 2, 0, "R11");

    // R12: partial power-down opcode
    cs_n = 1'b0; tick(2);
    for (int i = 7; i >= 3; i--) pair({1'b0, 1'b1 & (8'hB9 >> i)});
    cs_n = 1'b1; tick(6);
    chk(pwr_down == 1'b0, "R12", pwr_down, 1'b0);
    frame(8'h9F, 8'h00, 1, 1, "R12");

    // R8 enter power-down
    frame(8'hB9, 8'h00, 0, 0, "R8");
    chk(pwr_down == 1'b1, "R8", pwr_down, 1'b1);
    // R9 ignored commands
    frame(8'h9F, 8'h00, 2, 0, "R9");
    frame(8'h4B, 8'h00, 1, 0, "R9");
    frame(8'hB9, 8'h00, 0, 0, "R9");
    chk(pwr_down == 1'b1, "R9", pwr_down, 1'b1);
    // R5/R10 release answers with device id
    frame(8'hAB, 8'h00, 2, 1, "R5");
    chk(pwr_down == 1'b1, "R10", pwr_down, 1'b1);
    frame(8'h9F, 8'h00, 1, 0, "R10");
    chk(pwr_down == 1'b1, "R10", pwr_down, 1'b1);
    tick(P_REL);
    chk(pwr_down == 1'b0, "R10", pwr_down, 1'b0);
    frame(8'h9F, 8'h00, 3, 1, "R10");

    // R10 exact release timing
    frame(8'hB9, 8'h00, 0, 0, "R8");
    cs_n = 1'b0; tick(2);
    send_single(8'hAB);
    cs_n = 1'b1; tick(P_REL - 2);
    chk(pwr_down == 1'b1, "R10", pwr_down, 1'b1);
    tick(4);
    chk(pwr_down == 1'b0, "R10", pwr_down, 1'b0);

    // random mix
    for (int r = 0; r < 24; r++) begin
      logic [7:0] op, alo;
      op  = ops[$urandom_range(0, 4)];
      alo = ($urandom_range(0, 1) == 1) ? 8'h01 : 8'($urandom) & 8'hFE;
      frame(op, alo, $urandom_range(1, 9), 1,
            op == 8'h9F ? "R2" : op == 8'h90 ? "R3" : op == 8'h92 ? "R4" :
            op == 8'hAB ? "R5" : "R6");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule